// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps wall-clock time as six packed-BCD bytes: seconds, minutes, hours (24-hour), day of month, month and a two-digit year. A slow tick strobe, nominally 32768 per second, is divided down to one-second steps. A carry chain moves each step up through the fields. It honours the length of each month, including February in leap years. A leap year is a two-digit year divisible by four.

A byte-wide register port gives software access to the time, a six-field alarm, a run control bit, a status register and an interrupt-enable register. Writes to a time field are held back and take effect at the next tick. That tick also restarts the sub-second count. Status event bits are sticky and are cleared by writing ones. The interrupt line is registered.

The register map uses byte offsets, with bits [1:0] of the address ignored:

- Time fields: 0x00 seconds, 0x04 minutes, 0x08 hours, 0x0C day, 0x10 month, 0x14 year.
- Alarm fields: the same order, starting at 0x20.
- Control at 0x40, status at 0x44, interrupt enable at 0x48.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the time reads 00:00:00, day 0x01, month 0x01, year 0x00. Status reads 0x80 (power-up bit 7 set). Control, interrupt enable and `irq` are all 0.
- R2: While control bit 0 (run) is 1, the seconds field advances by one after every TICKS_PER_SEC ticks. While run is 0, ticks leave the time unchanged.
- R3: Seconds and minutes wrap from 0x59 to 0x00 and hours from 0x23 to 0x00. Each wrap carries one into the next field.
- R4: The day wraps to 0x01 after the last day of the month. That is 30 for months 04, 06, 09 and 11, and 31 for the other months. February has 29 days when the year is divisible by 4 (including 00) and 28 otherwise. Month 0x12 wraps to 0x01 and carries into the year; year 0x99 wraps to 0x00.
- R5: A write to a time field does not show on reads until the next tick. That tick loads the value, does not advance the time, and restarts the sub-second count. The next advance then comes exactly TICKS_PER_SEC ticks later.
- R6: Status bit 6 (alarm) sets after a time update only when all six time fields equal the six alarm fields. A difference in any single field keeps it clear.
- R7: Writing 1 to any of status bits 7..2 clears that bit. Writing 0 leaves it unchanged. Only reset sets bit 7.
- R8: Each advance sets status bit 2. Bit 3 also sets when the seconds wrap, bit 4 when the minutes wrap as well, and bit 5 when the hours wrap as well.
- R9: Status bit 1 mirrors the run bit. Status bit 0 (busy) is 1 while run is 1 and the next tick will advance the seconds.
- R10: `irq` is a register loaded each clock with (status bit 6 AND enable bit 3) OR (status bit 2 AND enable bit 2). Enable bits 3 and 2 are at offset 0x48.
- R11: `bus_rdata` shows the register addressed in the previous clock. Control reads back bit 0, and the enable register reads back bits 3 and 2. Unmapped offsets read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock strobe per 32 kHz period |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions on field legality assume that software writes only valid BCD values. They also assume that a full date is written together, so the day never exceeds the length of its month after a load. The assertions further assume that a time field is not rewritten in the same clock as a pending load of that field. The stimulus respects all of this: it writes complete legal dates while the clock is stopped, and it issues ticks only between bus operations, never during them. Month-end, leap-year and year-wrap cases are therefore reached by loading the second just before each boundary and then stepping exactly one second.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NFIELD   = 6;
  localparam int IDX_SEC  = 0;
  localparam int IDX_ALM0 = 8;
  localparam int IDX_CTRL = 16;
  localparam int IDX_STAT = 17;
  localparam int IDX_IEN  = 18;

  typedef logic [7:0] bcd8_t;

  function automatic bcd8_t bcd_inc(bcd8_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'h0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic bcd_leap(bcd8_t yr);
    if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction

  function automatic bcd8_t month_last(bcd8_t mon, bcd8_t yr);
    case (mon)
      8'h02: return bcd_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_subsec.sv
module rtc_subsec #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run,
  input  logic restart,
  output logic adv,
  output logic busy
);
  localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (tick) begin
      if (restart) cnt <= '0;
      else if (run) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign busy = run & (cnt == LAST);
  assign adv  = tick & ~restart & busy;

  // R2: the count stays still without a tick
  p_hold_without_tick_r2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar import rtc_pkg::*; (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick,
  input  logic                   adv,
  input  logic [NFIELD-1:0]      fld_wr,
  input  logic [7:0]             wdata,
  output logic [NFIELD-1:0][7:0] tm,
  output logic                   apply,
  output logic [3:0]             ev
);
  logic [NFIELD-1:0]      pend;
  logic [NFIELD-1:0][7:0] pval;
  logic [NFIELD-1:0][7:0] nt;
  logic                   day_wrap, mon_wrap;

  assign apply = tick & (|pend);

  always_comb begin
    ev[0] = adv;
    ev[1] = ev[0] & (tm[0] == 8'h59);
    ev[2] = ev[1] & (tm[1] == 8'h59);
    ev[3] = ev[2] & (tm[2] == 8'h23);
    day_wrap = tm[3] == month_last(tm[4], tm[5]);
    mon_wrap = day_wrap & (tm[4] == 8'h12);
    nt = tm;
    if (ev[0]) nt[0] = ev[1] ? 8'h00 : bcd_inc(tm[0]);
    if (ev[1]) nt[1] = ev[2] ? 8'h00 : bcd_inc(tm[1]);
    if (ev[2]) nt[2] = ev[3] ? 8'h00 : bcd_inc(tm[2]);
    if (ev[3]) begin
      nt[3] = day_wrap ? 8'h01 : bcd_inc(tm[3]);
      if (day_wrap) nt[4] = mon_wrap ? 8'h01 : bcd_inc(tm[4]);
      if (mon_wrap) nt[5] = (tm[5] == 8'h99) ? 8'h00 : bcd_inc(tm[5]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tm   <= {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
      pend <= '0;
      pval <= '0;
    end else begin
      if (apply) begin
        for (int f = 0; f < NFIELD; f++)
          if (pend[f]) tm[f] <= pval[f];
      end else begin
        tm <= nt;
      end
      for (int f = 0; f < NFIELD; f++) begin
        if (fld_wr[f]) begin
          pend[f] <= 1'b1;
          pval[f] <= wdata;
        end else if (apply) begin
          pend[f] <= 1'b0;
        end
      end
    end
  end

  // R3: seconds stay a legal BCD value
  p_sec_legal_r3: assert property (@(posedge clk) disable iff (rst)
    (tm[0][3:0] <= 4'd9) && (tm[0] <= 8'h59));
  // R4: day stays within the current month
  p_day_legal_r4: assert property (@(posedge clk) disable iff (rst)
    (tm[3] != 8'h00) && (tm[3] <= month_last(tm[4], tm[5])));
  // R5: a load never coincides with an advance
  p_load_blocks_step_r5: assert property (@(posedge clk) disable iff (rst)
    apply |-> !adv);
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc import rtc_pkg::*; #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int ADDR_W        = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0]      word;
  logic [NFIELD-1:0]      tm_wr, alm_wr;
  logic [NFIELD-1:0][7:0] tm, alm;
  logic                   apply, adv, busy;
  logic [3:0]             ev, st_ev;
  logic                   st_pwr, st_alarm, run_q, en_al, en_tm, upd_q;
  logic                   ctl_wr, st_wr, ien_wr;
  logic [7:0]             rd_mux;

  assign word   = bus_addr[ADDR_W-1:2];
  assign ctl_wr = bus_wr & (word == WORD_W'(IDX_CTRL));
  assign st_wr  = bus_wr & (word == WORD_W'(IDX_STAT));
  assign ien_wr = bus_wr & (word == WORD_W'(IDX_IEN));

  for (genvar g = 0; g < NFIELD; g++) begin : g_dec
    assign tm_wr[g]  = bus_wr & (word == WORD_W'(IDX_SEC + g));
    assign alm_wr[g] = bus_wr & (word == WORD_W'(IDX_ALM0 + g));
  end

  rtc_subsec #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_subsec (
    .clk(clk), .rst(rst), .tick(tick), .run(run_q), .restart(apply),
    .adv(adv), .busy(busy)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst(rst), .tick(tick), .adv(adv), .fld_wr(tm_wr),
    .wdata(bus_wdata), .tm(tm), .apply(apply), .ev(ev)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      alm      <= '0;
      st_pwr   <= 1'b1;
      st_alarm <= 1'b0;
      st_ev    <= '0;
      run_q    <= 1'b0;
      en_al    <= 1'b0;
      en_tm    <= 1'b0;
      upd_q    <= 1'b0;
      irq      <= 1'b0;
      bus_rdata <= '0;
    end else begin
      for (int f = 0; f < NFIELD; f++)
        if (alm_wr[f]) alm[f] <= bus_wdata;
      if (st_wr & bus_wdata[7]) st_pwr <= 1'b0;
      if (upd_q && (tm == alm)) st_alarm <= 1'b1;
      else if (st_wr & bus_wdata[6]) st_alarm <= 1'b0;
      for (int k = 0; k < 4; k++) begin
        if (ev[k]) st_ev[k] <= 1'b1;
        else if (st_wr & bus_wdata[2+k]) st_ev[k] <= 1'b0;
      end
      if (ctl_wr) run_q <= bus_wdata[0];
      if (ien_wr) begin
        en_al <= bus_wdata[3];
        en_tm <= bus_wdata[2];
      end
      upd_q     <= apply | adv;
      irq       <= (st_alarm & en_al) | (st_ev[0] & en_tm);
      bus_rdata <= rd_mux;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NFIELD; i++) begin
      if (word == WORD_W'(IDX_SEC + i))  rd_mux = tm[i];
      if (word == WORD_W'(IDX_ALM0 + i)) rd_mux = alm[i];
    end
    if (word == WORD_W'(IDX_CTRL)) rd_mux = {7'b0, run_q};
    if (word == WORD_W'(IDX_STAT)) rd_mux = {st_pwr, st_alarm, st_ev, run_q, busy};
    if (word == WORD_W'(IDX_IEN))  rd_mux = {4'b0, en_al, en_tm, 2'b0};
  end

  // R6: the alarm flag rises only after a time update
  p_alarm_after_update_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(st_alarm) |-> $past(upd_q));
  // R7: the power-up flag is never set outside reset
  p_pwr_only_falls_r7: assert property (@(posedge clk) disable iff (rst)
    !$rose(st_pwr));
  // R9: busy is only reported while running
  p_busy_needs_run_r9: assert property (@(posedge clk) disable iff (rst)
    busy |-> run_q);
  // R10: an interrupt always has a pending source behind it
  p_irq_has_source_r10: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(st_alarm | st_ev[0]));
endmodule

// File: tb/tb_bcd_rtc.sv
module tb_bcd_rtc;
  localparam int TPS = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq;

  int n_checks = 0;
  int n_fail   = 0;

  bcd_rtc #(.TICKS_PER_SEC(TPS), .ADDR_W(8)) dut (
    .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model, binary time fields
  int m_time[6], m_pend[6], m_pval[6], m_alm[6], m_ev[4];
  int m_cnt, m_run, m_pwr, m_al, m_enal, m_entm, m_upd;
  int exp_rdata, exp_irq;

  function automatic int to_bcd(int x); return (x / 10) * 16 + x % 10; endfunction
  function automatic int from_bcd(int x); return (x / 16) * 10 + x % 16; endfunction
  function automatic int dim(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction
  function automatic int m_read(int a);
    int w = a / 4;
    if (w < 6) return to_bcd(m_time[w]);
    if (w >= 8 && w < 14) return m_alm[w-8];
    if (w == 16) return m_run;
    if (w == 17) return m_pwr*128 + m_al*64 + m_ev[3]*32 + m_ev[2]*16 + m_ev[1]*8 +
                        m_ev[0]*4 + m_run*2 + ((m_run != 0 && m_cnt == TPS-1) ? 1 : 0);
    if (w == 18) return m_enal*8 + m_entm*4;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_time = '{0, 0, 0, 1, 1, 0};
      foreach (m_pend[i]) begin m_pend[i] = 0; m_pval[i] = 0; m_alm[i] = 0; end
      foreach (m_ev[i]) m_ev[i] = 0;
      m_cnt = 0; m_run = 0; m_pwr = 1; m_al = 0; m_enal = 0; m_entm = 0; m_upd = 0;
      exp_rdata = 0; exp_irq = 0;
    end else begin
      int w, anyp, apply, adv, match, wst;
      int e[4];
      w = bus_addr / 4;
      exp_rdata = m_read(bus_addr);
      exp_irq = (m_al & m_enal) | (m_ev[0] & m_entm);
      anyp = 0;
      foreach (m_pend[i]) if (m_pend[i] != 0) anyp = 1;
      apply = (tick && anyp) ? 1 : 0;
      adv = (tick && m_run != 0 && apply == 0 && m_cnt == TPS-1) ? 1 : 0;
      match = 1;
      foreach (m_alm[i]) if (to_bcd(m_time[i]) != m_alm[i]) match = 0;
      wst = (bus_wr && w == 17) ? 1 : 0;
      if (m_upd != 0 && match != 0) m_al = 1;
      else if (wst != 0 && bus_wdata[6]) m_al = 0;
      e[0] = adv;
      e[1] = (e[0] != 0 && m_time[0] == 59) ? 1 : 0;
      e[2] = (e[1] != 0 && m_time[1] == 59) ? 1 : 0;
      e[3] = (e[2] != 0 && m_time[2] == 23) ? 1 : 0;
      for (int k = 0; k < 4; k++)
        if (e[k] != 0) m_ev[k] = 1;
        else if (wst != 0 && bus_wdata[2+k]) m_ev[k] = 0;
      if (wst != 0 && bus_wdata[7]) m_pwr = 0;
      if (tick) begin
        if (apply != 0) m_cnt = 0;
        else if (m_run != 0) m_cnt = (m_cnt == TPS-1) ? 0 : m_cnt + 1;
      end
      if (apply != 0) begin
        foreach (m_pend[i]) if (m_pend[i] != 0) m_time[i] = m_pval[i];
      end else if (adv != 0) begin
        m_time[0]++;
        if (m_time[0] == 60) begin
          m_time[0] = 0; m_time[1]++;
          if (m_time[1] == 60) begin
            m_time[1] = 0; m_time[2]++;
            if (m_time[2] == 24) begin
              m_time[2] = 0;
              if (m_time[3] == dim(m_time[4], m_time[5])) begin
                m_time[3] = 1; m_time[4]++;
                if (m_time[4] == 13) begin
                  m_time[4] = 1; m_time[5] = (m_time[5] + 1) % 100;
                end
              end else m_time[3]++;
            end
          end
        end
      end
      for (int f = 0; f < 6; f++)
        if (bus_wr && w == f) begin m_pend[f] = 1; m_pval[f] = from_bcd(bus_wdata); end
        else if (apply != 0) m_pend[f] = 0;
      if (bus_wr && w >= 8 && w < 14) m_alm[w-8] = bus_wdata;
      if (bus_wr && w == 16) m_run = bus_wdata[0];
      if (bus_wr && w == 18) begin m_enal = bus_wdata[3]; m_entm = bus_wdata[2]; end
      m_upd = (apply != 0 || adv != 0) ? 1 : 0;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check("R11 read path", bus_rdata, exp_rdata);
      check("R10 irq", irq, exp_irq);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask
  task automatic rd(input logic [7:0] a, output int v);
    @(negedge clk); bus_addr = a; bus_wr = 1'b0;
    @(negedge clk); v = bus_rdata;
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask
  task automatic set_time(input logic [7:0] y, mo, d, h, mi, s);
    wr(8'h14, y); wr(8'h10, mo); wr(8'h0C, d);
    wr(8'h08, h); wr(8'h04, mi); wr(8'h00, s);
    ticks(1);
  endtask
  task automatic set_alarm(input logic [7:0] y, mo, d, h, mi, s);
    wr(8'h34, y); wr(8'h30, mo); wr(8'h2C, d);
    wr(8'h28, h); wr(8'h24, mi); wr(8'h20, s);
  endtask
  task automatic step_second();
    wr(8'h40, 8'h01); ticks(TPS); wr(8'h40, 8'h00);
  endtask
  task automatic expect_time(input string req, input int y, mo, d, h, mi, s);
    int v;
    rd(8'h14, v); check(req, v, y);
    rd(8'h10, v); check(req, v, mo);
    rd(8'h0C, v); check(req, v, d);
    rd(8'h08, v); check(req, v, h);
    rd(8'h04, v); check(req, v, mi);
    rd(8'h00, v); check(req, v, s);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    expect_time("R1 reset time", 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
    rd(8'h44, v); check("R1 status", v, 8'h80);
    rd(8'h40, v); check("R1 ctrl", v, 0);
    rd(8'h48, v); check("R1 enable", v, 0);
    check("R1 irq", irq, 0);
    rd(8'h3C, v); check("R11 unmapped", v, 0);
    // R7 write-one-to-clear
    wr(8'h44, 8'h00); rd(8'h44, v); check("R7 zero keeps", v, 8'h80);
    wr(8'h44, 8'h80); rd(8'h44, v); check("R7 one clears", v, 8'h00);
    // R5 deferred write
    wr(8'h00, 8'h44); rd(8'h00, v); check("R5 before tick", v, 8'h00);
    set_time(8'h45, 8'h06, 8'h15, 8'h12, 8'h30, 8'h44);
    expect_time("R5 loaded", 8'h45, 8'h06, 8'h15, 8'h12, 8'h30, 8'h44);
    // R6 alarm match, R10 irq
    set_alarm(8'h45, 8'h06, 8'h15, 8'h12, 8'h30, 8'h45);
    wr(8'h48, 8'h08); rd(8'h48, v); check("R11 enable readback", v, 8'h08);
    step_second();
    rd(8'h44, v); check("R6 alarm set", v, 8'h44);
    check("R10 alarm irq", irq, 1);
    wr(8'h44, 8'h40); rd(8'h44, v); check("R7 alarm cleared", v, 8'h04);
    check("R10 irq dropped", irq, 0);
    wr(8'h48, 8'h04); @(negedge clk); check("R10 timer irq", irq, 1);
    wr(8'h44, 8'h04); @(negedge clk); check("R10 timer irq cleared", irq, 0);
    wr(8'h48, 8'h00);
    // R6 one field differs
    wr(8'h30, 8'h07);
    set_time(8'h45, 8'h06, 8'h15, 8'h12, 8'h30, 8'h44);
    step_second();
    rd(8'h44, v); check("R6 month differs", v, 8'h04);
    // R3 R4 R8 full carry and year wrap
    set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
    wr(8'h44, 8'hFC);
    step_second();
    expect_time("R4 year wrap", 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
    rd(8'h44, v); check("R8 all events", v, 8'h3C);
    // R4 leap February
    set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    step_second();
    expect_time("R4 leap 29", 8'h24, 8'h02, 8'h29, 8'h00, 8'h00, 8'h00);
    set_time(8'h24, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59);
    step_second();
    expect_time("R4 leap end", 8'h24, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00);
    set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    step_second();
    expect_time("R4 common Feb", 8'h23, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00);
    set_time(8'h10, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
    step_second();
    expect_time("R4 30-day month", 8'h10, 8'h05, 8'h01, 8'h00, 8'h00, 8'h00);
    // R3 R8 minute carry only
    set_time(8'h10, 8'h05, 8'h01, 8'h10, 8'h14, 8'h59);
    wr(8'h44, 8'hFC);
    step_second();
    expect_time("R3 minute carry", 8'h10, 8'h05, 8'h01, 8'h10, 8'h15, 8'h00);
    rd(8'h44, v); check("R8 minute events", v, 8'h0C);
    // R9 busy and R2 stepping
    wr(8'h44, 8'hFC);
    wr(8'h40, 8'h01);
    ticks(TPS - 1);
    rd(8'h44, v); check("R9 busy high", v, 8'h03);
    ticks(1);
    rd(8'h44, v); check("R9 busy low after step", v, 8'h06);
    rd(8'h00, v); check("R2 one second", v, 8'h01);
    // R5 restart of sub-second count
    ticks(2);
    wr(8'h00, 8'h10);
    ticks(1);
    rd(8'h00, v); check("R5 applied", v, 8'h10);
    ticks(TPS - 1);
    rd(8'h00, v); check("R5 count restarted", v, 8'h10);
    ticks(1);
    rd(8'h00, v); check("R5 full second", v, 8'h11);
    // R2 stopped clock ignores ticks
    wr(8'h40, 8'h00);
    rd(8'h40, v); check("R11 ctrl readback", v, 0);
    ticks(2 * TPS);
    rd(8'h00, v); check("R2 stopped", v, 8'h11);
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule